// File: doc/BRIEF.md
# Acquisition Controller Host Register Block

This block is the software-facing side of an acquisition controller that coordinates a chain of digitizers sharing a command bus. A host reaches it through a 16-bit bus with a chip-select, a read/write flag and an acknowledge. The upper address bits pick a 256-byte window that is compared with a base value set by jumpers. Inside that window the host can set the reject-window delay, drive the control bits that feed the event sequencer, read a live image of the command-bus lines and the sequencer's event count, and choose which internal signal drives a monitor output.

Two write-only offsets have side effects but keep no data. A write to one clears the event counter. A write to the other arms a single event in single-shot mode. Each write to either offset produces a one-cycle pulse. A second monitor output is a plain level that software sets, so it can be used to produce pulses by hand. The sequencer itself sits outside the block: it uses the control outputs and the strobes, and it supplies the status lines, the event count and the monitor sources.

Each clock edge that sees the chip-select high with an address inside the window counts as one access. Read data and acknowledge are registered and appear in the cycle that follows.

Top module: `acq_host_regs`

## Requirements
- R1: An access is a clock edge with `bus_cs` high. When `bus_addr[15:8]` equals `base_sel`, `bus_ack` is high in the next cycle. When it does not, `bus_ack` stays low and the access changes nothing.
- R2: Byte offset 0 holds the 8-bit reject delay, driven on `delay_val`. Writes keep `bus_wdata[7:0]`, and reads return the delay in bits 7:0 with the upper bits zero.
- R3: Byte offset 2 holds the control word: bit 0 `acq_enable`, bit 1 `seq_reset`, bit 2 `gate_enable`, bit 3 `single_shot`. Writing 1 selects buffered acquisition, writing 9 selects single-shot acquisition, and only bits 3:0 are kept.
- R4: Byte offset 4 is read-only and returns the live `cbus_lines`. Bit 0 is the command strobe, bit 1 accepted, bit 2 gate, bit 3 global reject, bit 4 global trigger and bit 5 inhibit. Writes to it change nothing.
- R5: Byte offset 6 is read-only and returns `evcnt` in bits 7:0.
- R6: Every write to byte offset 16 raises `evt_clear` for exactly one cycle, starting in the cycle after the access, whatever the data.
- R7: Every write to byte offset 20 raises `arm_pulse` for exactly one cycle, starting in the cycle after the access, whatever the data.
- R8: Byte offset 8 holds a 4-bit monitor select. One cycle after the select or a source changes, `mon2_out` shows the chosen source. Codes 0 to 7 pick `src_eject`, `src_reject`, `cbus_lines[0]`, `src_adc_rst`, `src_armed`, `cbus_lines[3]`, `cbus_lines[4]` and `cbus_lines[5]`.
- R9: Monitor select codes 8 to 15 drive `mon2_out` low.
- R10: Byte offset 22 holds one bit. `mon0_out` follows bit 0 of the last write and reads back in bit 0.
- R11: Reads from byte offsets 16, 20 and from unmapped offsets in the window return zero and are acknowledged.
- R12: After reset every stored register is zero, so acquisition is disabled, both strobes are low and both monitor outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cs | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access acknowledge |
| base_sel | input | 8 | Window base from jumpers (fitted jumper = 0) |
| cbus_lines | input | 6 | Live command-bus lines |
| evcnt | input | 8 | Event count from the sequencer |
| src_eject | input | 1 | Monitor source: eject sample |
| src_reject | input | 1 | Monitor source: reject input |
| src_adc_rst | input | 1 | Monitor source: digitizer reset |
| src_armed | input | 1 | Monitor source: armed state |
| delay_val | output | 8 | Reject-window delay |
| acq_enable | output | 1 | Acquisition enable |
| seq_reset | output | 1 | Sequencer reset |
| gate_enable | output | 1 | Gate signal enable |
| single_shot | output | 1 | Single-shot mode |
| evt_clear | output | 1 | One-cycle event-counter clear |
| arm_pulse | output | 1 | One-cycle single-shot arm |
| mon2_out | output | 1 | Selected monitor output |
| mon0_out | output | 1 | Software-set monitor level |

## Verification
The assertions check the properties that hold on every cycle. Each access is acknowledged when its address is in the window and not acknowledged when it is outside. The clear and arm strobes rise exactly when a write hits their offsets and at no other time. Reads of the write-only offsets return zero, out-of-range monitor codes hold the output low, and the software level follows the written bit. Other behaviour can only be shown by the bench's scenarios: stored values reading back with their unused bits dropped, the status and count reads reflecting the live inputs, the mapping from each monitor code to its source, writes to read-only or out-of-window addresses leaving state unchanged, and the zero state after reset.

// File: rtl/acqreg_pkg.sv
package acqreg_pkg;

   // byte offsets inside the window; bit 0 of the address is ignored
   localparam int OFS_DELAY = 0;
   localparam int OFS_CTRL  = 2;
   localparam int OFS_STAT  = 4;
   localparam int OFS_EVCNT = 6;
   localparam int OFS_MSEL  = 8;
   localparam int OFS_CLR   = 16;
   localparam int OFS_ARM   = 20;
   localparam int OFS_MON0  = 22;

   // number of command-bus status lines and monitor sources
   localparam int CBUS_LINES = 6;
   localparam int MON_SRCS   = 8;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DELAY,
      SEL_CTRL,
      SEL_STAT,
      SEL_EVCNT,
      SEL_MSEL,
      SEL_CLR,
      SEL_ARM,
      SEL_MON0
   } reg_sel_e;

   // packed: last member is bit 0
   typedef struct packed {
      logic single;
      logic gate_en;
      logic seq_rst;
      logic acq_en;
   } ctrl_t;

endpackage

// File: rtl/acqreg_decode.sv
module acqreg_decode
   import acqreg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int WIN_LSB = 8
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [ADDR_W-WIN_LSB-1:0] base_sel,
   output logic                      hit,
   output reg_sel_e                  sel
);

   localparam int OFS_W = WIN_LSB;

   logic [OFS_W-1:0] ofs;

   assign ofs = {addr[OFS_W-1:1], 1'b0};
   assign hit = (addr[ADDR_W-1:OFS_W] == base_sel);

   always_comb begin
      case (int'(ofs))
         OFS_DELAY: sel = SEL_DELAY;
         OFS_CTRL:  sel = SEL_CTRL;
         OFS_STAT:  sel = SEL_STAT;
         OFS_EVCNT: sel = SEL_EVCNT;
         OFS_MSEL:  sel = SEL_MSEL;
         OFS_CLR:   sel = SEL_CLR;
         OFS_ARM:   sel = SEL_ARM;
         OFS_MON0:  sel = SEL_MON0;
         default:   sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/acqreg_bank.sv
module acqreg_bank
   import acqreg_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DELAY_W = 8,
   parameter int CNT_W   = 8,
   parameter int SEL_W   = 4,
   parameter int LINES_W = 6,
   parameter int CTRL_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               access,
   input  logic               we,
   input  reg_sel_e           sel,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [LINES_W-1:0] cbus_lines,
   input  logic [CNT_W-1:0]   evt_count,
   output logic [DELAY_W-1:0] delay_q,
   output logic [CTRL_W-1:0]  ctrl_q,
   output logic [SEL_W-1:0]   msel_q,
   output logic               mon0_q,
   output logic               evt_clr_p,
   output logic               arm_p,
   output logic [DATA_W-1:0]  rdata,
   output logic               ack
);

   logic [DATA_W-1:0] rd_mux;
   logic              wr_hit;
   logic              rd_hit;

   assign wr_hit = access && we;
   assign rd_hit = access && !we;

   always_comb begin
      case (sel)
         SEL_DELAY: rd_mux = DATA_W'(delay_q);
         SEL_CTRL:  rd_mux = DATA_W'(ctrl_q);
         SEL_STAT:  rd_mux = DATA_W'(cbus_lines);
         SEL_EVCNT: rd_mux = DATA_W'(evt_count);
         SEL_MSEL:  rd_mux = DATA_W'(msel_q);
         SEL_MON0:  rd_mux = DATA_W'(mon0_q);
         default:   rd_mux = '0;
      endcase
   end

   // handshake, read data and strobes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack       <= 1'b0;
         rdata     <= '0;
         evt_clr_p <= 1'b0;
         arm_p     <= 1'b0;
      end else begin
         ack       <= access;
         rdata     <= rd_hit ? rd_mux : '0;
         evt_clr_p <= wr_hit && (sel == SEL_CLR);
         arm_p     <= wr_hit && (sel == SEL_ARM);
      end
   end

   // stored registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         delay_q <= '0;
         ctrl_q  <= '0;
         msel_q  <= '0;
         mon0_q  <= 1'b0;
      end else if (wr_hit) begin
         case (sel)
            SEL_DELAY: delay_q <= wdata[DELAY_W-1:0];
            SEL_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
            SEL_MSEL:  msel_q  <= wdata[SEL_W-1:0];
            SEL_MON0:  mon0_q  <= wdata[0];
            default:   ;
         endcase
      end
   end

endmodule

// File: rtl/acqreg_monmux.sv
module acqreg_monmux #(
   parameter int SEL_W     = 4,
   parameter int NSRC      = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic [NSRC-1:0]  src,
   output logic             mon
);

   localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   logic pick;

   always_comb begin
      if (int'(sel) < NSRC) pick = src[sel[IDX_W-1:0]];
      else                  pick = 1'b0;
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) mon <= 1'b0;
         else        mon <= pick;
      end
   end else begin : g_comb
      assign mon = pick;
   end

endmodule

// File: rtl/acq_host_regs.sv
module acq_host_regs
   import acqreg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int WIN_LSB = 8,
   parameter int DELAY_W = 8,
   parameter int CNT_W   = 8,
   parameter int SEL_W   = 4,
   parameter bit MON_REG = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bus_cs,
   input  logic                      bus_we,
   input  logic [ADDR_W-1:0]         bus_addr,
   input  logic [DATA_W-1:0]         bus_wdata,
   output logic [DATA_W-1:0]         bus_rdata,
   output logic                      bus_ack,
   input  logic [ADDR_W-WIN_LSB-1:0] base_sel,
   input  logic [CBUS_LINES-1:0]     cbus_lines,
   input  logic [CNT_W-1:0]          evcnt,
   input  logic                      src_eject,
   input  logic                      src_reject,
   input  logic                      src_adc_rst,
   input  logic                      src_armed,
   output logic [DELAY_W-1:0]        delay_val,
   output logic                      acq_enable,
   output logic                      seq_reset,
   output logic                      gate_enable,
   output logic                      single_shot,
   output logic                      evt_clear,
   output logic                      arm_pulse,
   output logic                      mon2_out,
   output logic                      mon0_out
);

   localparam int CTRL_W = $bits(ctrl_t);

   // elaboration-time parameter checks
   if (ADDR_W <= WIN_LSB) begin : g_bad_addr
      $error("ADDR_W must exceed WIN_LSB");
   end
   if (WIN_LSB < 5) begin : g_bad_win
      $error("window too small for the offset map");
   end
   if (DATA_W < DELAY_W || DATA_W < CNT_W || DATA_W < CBUS_LINES) begin : g_bad_data
      $error("DATA_W too narrow for register contents");
   end
   if ((2 ** SEL_W) < MON_SRCS) begin : g_bad_sel
      $error("SEL_W cannot address every monitor source");
   end

   logic                hit;
   reg_sel_e            sel;
   logic [CTRL_W-1:0]   ctrl_raw;
   ctrl_t               ctrl;
   logic [SEL_W-1:0]    mon2_sel;
   logic [MON_SRCS-1:0] mon_src;

   acqreg_decode #(
      .ADDR_W  (ADDR_W),
      .WIN_LSB (WIN_LSB)
   ) u_dec (
      .addr     (bus_addr),
      .base_sel (base_sel),
      .hit      (hit),
      .sel      (sel)
   );

   acqreg_bank #(
      .DATA_W  (DATA_W),
      .DELAY_W (DELAY_W),
      .CNT_W   (CNT_W),
      .SEL_W   (SEL_W),
      .LINES_W (CBUS_LINES),
      .CTRL_W  (CTRL_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .access     (bus_cs && hit),
      .we         (bus_we),
      .sel        (sel),
      .wdata      (bus_wdata),
      .cbus_lines (cbus_lines),
      .evt_count  (evcnt),
      .delay_q    (delay_val),
      .ctrl_q     (ctrl_raw),
      .msel_q     (mon2_sel),
      .mon0_q     (mon0_out),
      .evt_clr_p  (evt_clear),
      .arm_p      (arm_pulse),
      .rdata      (bus_rdata),
      .ack        (bus_ack)
   );

   assign ctrl        = ctrl_t'(ctrl_raw);
   assign acq_enable  = ctrl.acq_en;
   assign seq_reset   = ctrl.seq_rst;
   assign gate_enable = ctrl.gate_en;
   assign single_shot = ctrl.single;

   // source order is the monitor code
   assign mon_src = {cbus_lines[5], cbus_lines[4], cbus_lines[3], src_armed,
                     src_adc_rst, cbus_lines[0], src_reject, src_eject};

   acqreg_monmux #(
      .SEL_W      (SEL_W),
      .NSRC       (MON_SRCS),
      .REGISTERED (MON_REG)
   ) u_mon2 (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (mon2_sel),
      .src   (mon_src),
      .mon   (mon2_out)
   );

endmodule

// File: rtl/acqreg_checker.sv
module acqreg_checker #(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int WIN_LSB = 8,
   parameter int SEL_W   = 4,
   parameter int NSRC    = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_cs,
   input logic                      bus_we,
   input logic [ADDR_W-1:0]         bus_addr,
   input logic [DATA_W-1:0]         bus_wdata,
   input logic [DATA_W-1:0]         bus_rdata,
   input logic                      bus_ack,
   input logic [ADDR_W-WIN_LSB-1:0] base_sel,
   input logic                      evt_clear,
   input logic                      arm_pulse,
   input logic [SEL_W-1:0]          msel,
   input logic                      mon2_out,
   input logic                      mon0_out
);

   logic             in_win;
   logic [WIN_LSB-1:0] offw;
   logic             wr_clr;
   logic             wr_arm;
   logic             rd_wo;
   logic             wr_mon0;

   assign in_win  = bus_cs && (bus_addr[ADDR_W-1:WIN_LSB] == base_sel);
   assign offw    = {bus_addr[WIN_LSB-1:1], 1'b0};
   assign wr_clr  = in_win && bus_we && (int'(offw) == 16);
   assign wr_arm  = in_win && bus_we && (int'(offw) == 20);
   assign rd_wo   = in_win && !bus_we && (int'(offw) == 16 || int'(offw) == 20);
   assign wr_mon0 = in_win && bus_we && (int'(offw) == 22);

   AST_ACK_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |=> bus_ack);                                         // R1
   AST_NO_ACK_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> !bus_ack);                                       // R1
   AST_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> evt_clear);                                       // R6
   AST_CLR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_clear |-> $past(wr_clr));                                // R6
   AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_arm |=> arm_pulse);                                       // R7
   AST_ARM_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      arm_pulse |-> $past(wr_arm));                                // R7
   AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wo |=> (bus_rdata == '0));                                // R11
   AST_HIGH_CODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(msel) >= NSRC) |=> !mon2_out);                         // R9
   AST_MON0_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mon0 |=> (mon0_out == $past(bus_wdata[0])));              // R10

endmodule

bind acq_host_regs acqreg_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .WIN_LSB (WIN_LSB),
   .SEL_W   (SEL_W),
   .NSRC    (8)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_cs    (bus_cs),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .bus_ack   (bus_ack),
   .base_sel  (base_sel),
   .evt_clear (evt_clear),
   .arm_pulse (arm_pulse),
   .msel      (mon2_sel),
   .mon2_out  (mon2_out),
   .mon0_out  (mon0_out)
);

// File: tb/acq_host_regs_tb.sv
module acq_host_regs_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_cs = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ack;
   logic [7:0]  base_sel = 8'h3C;
   logic [5:0]  cbus_lines = '0;
   logic [7:0]  evcnt = '0;
   logic        src_eject = 1'b0;
   logic        src_reject = 1'b0;
   logic        src_adc_rst = 1'b0;
   logic        src_armed = 1'b0;
   logic [7:0]  delay_val;
   logic        acq_enable, seq_reset, gate_enable, single_shot;
   logic        evt_clear, arm_pulse, mon2_out, mon0_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int    exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   acq_host_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .base_sel(base_sel), .cbus_lines(cbus_lines),
      .evcnt(evcnt), .src_eject(src_eject), .src_reject(src_reject),
      .src_adc_rst(src_adc_rst), .src_armed(src_armed), .delay_val(delay_val),
      .acq_enable(acq_enable), .seq_reset(seq_reset), .gate_enable(gate_enable),
      .single_shot(single_shot), .evt_clear(evt_clear), .arm_pulse(arm_pulse),
      .mon2_out(mon2_out), .mon0_out(mon0_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // driver: one access; in-window accesses push the expected read data
   task automatic acc(input bit we, input int ofs, input int wd, input int exp,
                      input string tag, input bit in_window = 1'b1);
      @(negedge clk);
      if (in_window) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
      bus_cs    = 1'b1;
      bus_we    = we;
      bus_addr  = {(in_window ? base_sel : base_sel + 8'h01), 8'(ofs)};
      bus_wdata = 16'(wd);
      @(posedge clk);
      @(negedge clk);
      bus_cs = 1'b0;
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_src(input logic [7:0] v);
      src_eject     = v[0];
      src_reject    = v[1];
      cbus_lines[0] = v[2];
      src_adc_rst   = v[3];
      src_armed     = v[4];
      cbus_lines[3] = v[5];
      cbus_lines[4] = v[6];
      cbus_lines[5] = v[7];
   endtask

   // monitor: pops expected data whenever an acknowledge appears
   always @(negedge clk) begin
      if (rst_n && bus_ack) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R1 ack without in-window access", 1, 0);
         end else begin
            automatic int    e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(int'(bus_rdata) == e, t, int'(bus_rdata), e);
         end
      end
   end

   initial begin
      #(20 * 100000);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk({delay_val, acq_enable, seq_reset, gate_enable, single_shot} == '0,
          "R12 stored outputs after reset", int'(delay_val), 0);
      chk({evt_clear, arm_pulse, mon2_out, mon0_out} == 4'b0,
          "R12 strobes and monitors after reset",
          int'({evt_clear, arm_pulse, mon2_out, mon0_out}), 0);
      acc(0, 2, 0, 16'h0000, "R12 control reads zero");
      acc(0, 8, 0, 16'h0000, "R12 monitor select reads zero");

      // R2 delay
      acc(1, 0, 16'h01A5, 0, "R2 write ack");
      chk(delay_val == 8'hA5, "R2 delay output", int'(delay_val), 'hA5);
      acc(0, 0, 0, 16'h00A5, "R2 delay readback upper zero");

      // R3 control
      acc(1, 2, 1, 0, "R3 write ack");
      chk({single_shot, gate_enable, seq_reset, acq_enable} == 4'b0001,
          "R3 buffered mode", int'({single_shot, gate_enable, seq_reset, acq_enable}), 1);
      acc(1, 2, 9, 0, "R3 write ack");
      chk({single_shot, gate_enable, seq_reset, acq_enable} == 4'b1001,
          "R3 single-shot mode", int'({single_shot, gate_enable, seq_reset, acq_enable}), 9);
      acc(1, 2, 16'hFFF6, 0, "R3 write ack");
      chk({single_shot, gate_enable, seq_reset, acq_enable} == 4'b0110,
          "R3 gate and reset bits", int'({single_shot, gate_enable, seq_reset, acq_enable}), 6);
      acc(0, 2, 0, 16'h0006, "R3 control readback keeps bits 3:0");

      // R1 out-of-window write is ignored
      acc(1, 2, 16'h000F, 0, "R1 miss", 1'b0);
      chk(!bus_ack, "R1 no ack outside window", int'(bus_ack), 0);
      chk(single_shot == 1'b0 && acq_enable == 1'b0, "R1 miss leaves control",
          int'({single_shot, acq_enable}), 0);
      acc(0, 2, 0, 16'h0006, "R1 control unchanged after miss");

      // R4 status
      cbus_lines = 6'b101010;
      acc(0, 4, 0, 16'h002A, "R4 status pattern A");
      acc(1, 4, 16'hFFFF, 0, "R4 write ack");
      cbus_lines = 6'b010101;
      acc(0, 4, 0, 16'h0015, "R4 status pattern B after write");
      chk(delay_val == 8'hA5, "R4 write to status changed nothing", int'(delay_val), 'hA5);

      // R5 event count
      evcnt = 8'h5C;
      acc(0, 6, 0, 16'h005C, "R5 event count");
      evcnt = 8'hFF;
      acc(0, 6, 0, 16'h00FF, "R5 event count full");

      // R6 clear strobe
      acc(1, 16, 16'h0000, 0, "R6 write ack");
      chk(evt_clear && !arm_pulse, "R6 clear pulse present", int'(evt_clear), 1);
      wait_cyc(1);
      chk(!evt_clear, "R6 clear pulse one cycle", int'(evt_clear), 0);

      // R7 arm strobe
      acc(1, 20, 16'hABCD, 0, "R7 write ack");
      chk(arm_pulse && !evt_clear, "R7 arm pulse present", int'(arm_pulse), 1);
      wait_cyc(1);
      chk(!arm_pulse, "R7 arm pulse one cycle", int'(arm_pulse), 0);

      // R11 reads of write-only and unmapped offsets
      acc(0, 16, 0, 0, "R11 read clear offset");
      acc(0, 20, 0, 0, "R11 read arm offset");
      acc(0, 10, 0, 0, "R11 read unmapped offset");
      chk(!evt_clear && !arm_pulse, "R11 reads raise no strobe",
          int'({evt_clear, arm_pulse}), 0);

      // R8 monitor select codes 0..7
      for (int k = 0; k < 8; k++) begin
         acc(1, 8, 16'hFFF0 | k, 0, "R8 write ack");
         set_src(8'(1 << k));
         wait_cyc(2);
         chk(mon2_out == 1'b1, $sformatf("R8 code %0d source high", k), int'(mon2_out), 1);
         set_src(~8'(1 << k));
         wait_cyc(2);
         chk(mon2_out == 1'b0, $sformatf("R8 code %0d source low", k), int'(mon2_out), 0);
      end
      acc(0, 8, 0, 16'h0007, "R8 select readback low 4 bits");

      // R9 codes 8..15
      set_src(8'hFF);
      for (int k = 8; k < 16; k++) begin
         acc(1, 8, k, 0, "R9 write ack");
         wait_cyc(2);
         chk(mon2_out == 1'b0, $sformatf("R9 code %0d low", k), int'(mon2_out), 0);
      end

      // R10 software monitor level
      acc(1, 22, 1, 0, "R10 write ack");
      chk(mon0_out == 1'b1, "R10 level high", int'(mon0_out), 1);
      acc(0, 22, 0, 16'h0001, "R10 readback");
      acc(1, 22, 0, 0, "R10 write ack");
      chk(mon0_out == 1'b0, "R10 level low", int'(mon0_out), 0);
      acc(1, 22, 2, 0, "R10 write ack");
      chk(mon0_out == 1'b0, "R10 only bit 0 counts", int'(mon0_out), 0);

      wait_cyc(2);
      chk(exp_q.size() == 0, "R1 every in-window access acknowledged", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule